// File: doc/BRIEF.md
# Status Pulse-Width Channel Detector

This block watches the active-low status line of a scanning eight-channel converter and works out which channel the converter is on. The converter pulls status low once per channel boundary. Boundaries are 80 clocks apart. An ordinary boundary holds status low for 8 clocks. The boundary that marks channel 0 holds it low for 72 clocks. The detector measures how long each low lasts and recognises the long marker. When it does, it raises a channel-0 level and emits a one-cycle interrupt strobe.

A small tracker counts the scan position. The converter's channel number steps down by one at each boundary and wraps from 0 to 7. The tracker follows this by decrementing on every falling edge of status, and it reloads to 0 on each marker. Until the first marker after reset, the tracker reports itself invalid. The block runs on the converter's own clock.

Top module: `stat_chan_detect`

## Requirements
- R1: While reset is held and on its release, `ch0_active`, `ch0_irq` and `chan_valid` are 0 and `chan_idx` is 0.
- R2: The status input passes through two flip-flops before any use, so every result below is counted from the first rising edge that samples the new input level.
- R3: A status low lasting 32 or more clocks sets `ch0_active` on the 34th rising edge, counting the first edge that samples status low as edge 1.
- R4: A status low lasting 31 clocks or fewer (for example 8, 9 or 31) never raises `ch0_active` or `ch0_irq`.
- R5: `ch0_irq` is high for exactly one cycle per detected low pulse, in the same cycle that `ch0_active` rises.
- R6: `ch0_active` stays high until status returns high. It clears on the third rising edge that samples status high, so a detected low of W clocks leaves the flag high for W-31 cycles.
- R7: The low-width counter saturates at 127. A low of 170 clocks produces one `ch0_irq` only, and `ch0_active` stays continuously high through the whole low.
- R8: A detection loads `chan_idx` with 0 and sets `chan_valid` to 1, one edge after the strobe.
- R9: While `chan_valid` is 1, each falling edge of the synchronised status decrements `chan_idx` by one, with 0 wrapping to 7. The update lands on the third rising edge after the input falls.
- R10: While `chan_valid` is 0, `chan_idx` stays at 0 and falling edges of status have no effect on it.
- R11: On an 80-clock scan grid, `chan_idx` reads 0 after a 72-clock marker and then reads 7, 6, 5, 4, 3, 2, 1 after each following 8-clock boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_n | input | 1 | Converter status line, active low |
| ch0_active | output | 1 | High while a recognised channel-0 marker is still low |
| ch0_irq | output | 1 | One-cycle strobe when the marker is recognised |
| chan_idx | output | 3 | Tracked channel number |
| chan_valid | output | 1 | High once a marker has been seen since reset |

## Verification
Every output is due a fixed number of rising edges after a status change. Counting the first edge that samples a low as edge 1, the flag and the strobe are due at edge 34. The tracker reload is due at edge 35, and a tracker decrement at edge 3. The flag clear is due at the third edge that samples status high. Each scenario drives status at a falling clock edge and samples the outputs at every following falling edge, indexed by how many rising edges have passed. From this it checks when the flag first rises, how many cycles it is high, how many strobes occur and at which index, and what the tracker reads at the end of the 80-clock slot. The expected tracker value is advanced in the bench from the pulse widths alone.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int unsigned SPD_SYNC_STAGES = 2;
    localparam int unsigned SPD_CNT_W       = 7;
    localparam int unsigned SPD_THRESH      = 32;
    localparam int unsigned SPD_CH_W        = 3;

    // Synchronised view of the status line.
    typedef struct packed {
        logic low;   // synchronised status is low
        logic fall;  // first cycle of a synchronised low
    } stat_evt_t;

    // Detector result.
    typedef struct packed {
        logic active;  // marker recognised and status still low
        logic strobe;  // single-cycle recognition pulse
    } det_t;

    function automatic logic edge_fall(input logic now_low, input logic was_low);
        return now_low & ~was_low;
    endfunction

endpackage

// File: rtl/spd_sync.sv
module spd_sync
    import spd_pkg::*;
#(
    parameter int unsigned STAGES = SPD_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      stat_n,
    output stat_evt_t evt
);

    logic [STAGES-1:0] chain_q;
    logic              was_low_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= stat_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) was_low_q <= 1'b0;
        else     was_low_q <= ~chain_q[STAGES-1];
    end

    always_comb begin
        evt.low  = ~chain_q[STAGES-1];
        evt.fall = edge_fall(~chain_q[STAGES-1], was_low_q);
    end

endmodule

// File: rtl/spd_width.sv
module spd_width
    import spd_pkg::*;
#(
    parameter int unsigned CNT_W  = SPD_CNT_W,
    parameter int unsigned THRESH = SPD_THRESH
) (
    input  logic      clk,
    input  logic      rst,
    input  stat_evt_t evt,
    output det_t      det
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HIT_AT  = CNT_W'(THRESH - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             strobe_q;
    logic             hit;

    assign hit = evt.low && (cnt_q == HIT_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            if (!evt.low)              cnt_q <= '0;
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
            strobe_q <= hit;
            if (!evt.low)  active_q <= 1'b0;
            else if (hit)  active_q <= 1'b1;
        end
    end

    always_comb begin
        det.active = active_q;
        det.strobe = strobe_q;
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q); // R5
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> active_q); // R5
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !evt.low |=> !active_q); // R6
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (evt.low && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R7

endmodule

// File: rtl/spd_tracker.sv
module spd_tracker
    import spd_pkg::*;
#(
    parameter int unsigned CH_W = SPD_CH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fall,
    input  logic            load,
    output logic [CH_W-1:0] chan,
    output logic            valid
);

    logic [CH_W-1:0] chan_q;
    logic            valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            chan_q  <= '0;
            valid_q <= 1'b1;
        end else if (fall && valid_q) begin
            chan_q  <= chan_q - CH_W'(1);
        end
    end

    assign chan  = chan_q;
    assign valid = valid_q;

    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        load |=> (chan_q == '0 && valid_q)); // R8
    AST_INVALID_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (chan_q == '0)); // R10

endmodule

// File: rtl/stat_chan_detect.sv
module stat_chan_detect
    import spd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SPD_SYNC_STAGES,
    parameter int unsigned CNT_W       = SPD_CNT_W,
    parameter int unsigned THRESH      = SPD_THRESH,
    parameter int unsigned CH_W        = SPD_CH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stat_n,
    output logic            ch0_active,
    output logic            ch0_irq,
    output logic [CH_W-1:0] chan_idx,
    output logic            chan_valid
);

    stat_evt_t evt;
    det_t      det;

    spd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .stat_n (stat_n),
        .evt    (evt)
    );

    spd_width #(.CNT_W(CNT_W), .THRESH(THRESH)) u_width (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .det (det)
    );

    spd_tracker #(.CH_W(CH_W)) u_track (
        .clk   (clk),
        .rst   (rst),
        .fall  (evt.fall),
        .load  (det.strobe),
        .chan  (chan_idx),
        .valid (chan_valid)
    );

    assign ch0_active = det.active;
    assign ch0_irq    = det.strobe;

endmodule

// File: tb/sim_stat_chan_detect.sv
module sim_stat_chan_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stat_n = 1'b1;
    logic       ch0_active;
    logic       ch0_irq;
    logic [2:0] chan_idx;
    logic       chan_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [2:0] exp_chan  = 3'd0;
    logic       exp_valid = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    stat_chan_detect u0 (
        .clk        (clk),
        .rst        (rst),
        .stat_n     (stat_n),
        .ch0_active (ch0_active),
        .ch0_irq    (ch0_irq),
        .chan_idx   (chan_idx),
        .chan_valid (chan_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge: status low for w clocks, then high for h clocks.
    task automatic pulse(input int w, input int h, input string ch_tag);
        int hi_cnt = 0;
        int first  = -1;
        int irq_cnt = 0;
        int irq_at = -1;
        stat_n = 1'b0;
        for (int i = 1; i <= w + h; i++) begin
            @(negedge clk);
            if (ch0_active) begin
                hi_cnt++;
                if (first < 0) first = i;
            end
            if (ch0_irq) begin
                irq_cnt++;
                if (irq_at < 0) irq_at = i;
            end
            if (i == w) stat_n = 1'b1;
        end
        if (w >= 32) begin
            exp_chan  = 3'd0;
            exp_valid = 1'b1;
            chk(first == 34, "R3 flag rise edge", first, 34);
            chk(irq_at == 34, "R5 strobe edge", irq_at, 34);
            chk(irq_cnt == 1, (w >= 160) ? "R7 single strobe" : "R5 strobe count", irq_cnt, 1);
            chk(hi_cnt == w - 31, (w >= 160) ? "R7 flag high span" : "R6 flag high span", hi_cnt, w - 31);
        end else begin
            if (exp_valid) exp_chan = exp_chan - 3'd1;
            chk(hi_cnt == 0, "R4 flag stays low", hi_cnt, 0);
            chk(irq_cnt == 0, "R4 no strobe", irq_cnt, 0);
        end
        chk(chan_valid == exp_valid, {ch_tag, " valid"}, int'(chan_valid), int'(exp_valid));
        chk(chan_idx == exp_chan, {ch_tag, " channel"}, int'(chan_idx), int'(exp_chan));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        stat_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(ch0_active == 1'b0, "R1 flag in reset", int'(ch0_active), 0);
        chk(ch0_irq == 1'b0, "R1 strobe in reset", int'(ch0_irq), 0);
        chk(chan_valid == 1'b0, "R1 valid in reset", int'(chan_valid), 0);
        chk(chan_idx == 3'd0, "R1 channel in reset", int'(chan_idx), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ch0_active == 1'b0 && chan_valid == 1'b0, "R1 after release", int'(ch0_active), 0);
    endtask

    task automatic t_before_marker;
        pulse(8, 72, "R10");   // R2 timing implicit in every window
        pulse(31, 49, "R10");
    endtask

    task automatic t_scan_grid;
        pulse(72, 8, "R8");
        for (int k = 0; k < 7; k++) pulse(8, 72, "R11");
        pulse(72, 8, "R11");
        pulse(8, 72, "R9");     // wrap 0 -> 7
    endtask

    task automatic t_corners;
        pulse(32, 48, "R8");
        pulse(33, 47, "R8");
        pulse(31, 49, "R9");
        pulse(9, 71, "R9");
        pulse(170, 10, "R7");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_before_marker();
        t_scan_grid();
        t_corners();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule